// File: doc/BRIEF.md
# Banked Nibble Data Memory with Row Register

This block is the working store of a small 4-bit controller core. It holds 256 words of 4 bits each. The address of a word is an 8-bit value: a 4-bit row above a 4-bit column. There are two ways to address a word, and both use the same array. A direct access supplies only a column number and always reaches row 0, so the sixteen words of row 0 serve as general registers. An indirect access takes its row from a 4-bit row register. Through that register every row can be reached, including row 0. Rows 1 to 3 can only be reached this way, and so can the 192 words of rows 4 to 15.

Three operations can change the row register: a load from the addressed memory word, a load from an immediate value, and a port write. No other operation touches it. The block also has a 16-bit table register. A table-load operation fills it from program memory through a 10-bit read address. A port-read operation then copies the table register back into data memory, one nibble per clock, while a busy output is high.

The decoder sends a 3-bit operation code each cycle, together with the addressing mode, a column, a 4-bit data value and a program address.

Top module: `nibble_bank_mem`

## Requirements
- R1: With `indirect`=0 the accessed word is row 0 at column `col`. `op`=1 (write) stores `wrData` there at the clock edge, and `rdData` shows that word combinationally.
- R2: With `indirect`=1 the accessed word is at row `rowSel`, column `col`, for every row 0x0 to 0xF.
- R3: `op`=2 loads `rowSel` from the word that is currently addressed, at the clock edge.
- R4: `op`=3 (immediate) and `op`=4 (port write) each load `rowSel` from `wrData`.
- R5: Every operation code other than 2, 3 and 4 leaves `rowSel` unchanged.
- R6: `progAddr` follows `tblAddr`. `op`=5 loads the 16-bit table register from `progData` at the clock edge.
- R7: `op`=6 starts a transfer at the accessed row and column. `busy` is then high for exactly 4 cycles. In those cycles, table nibble k (bits 4k+3:4k, k=0 first) is written to column (col+k) mod 16 of the same row, one nibble per edge.
- R8: While `busy` is high, every operation code is ignored: no write, no change to the row register, no table load.
- R9: When a word is written and read in the same cycle, `rdData` shows the old value until the edge.
- R10: Reset (active-low `rstN`) clears `rowSel` and the table register and holds `busy` low. The contents of memory are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation: 0 idle, 1 write, 2 row from memory, 3 row immediate, 4 row port write, 5 table load, 6 port read |
| indirect | input | 1 | 1 selects the row register as row, 0 selects row 0 |
| col | input | 4 | Column of the accessed word |
| wrData | input | 4 | Write data and source for row loads |
| tblAddr | input | 10 | Program address for a table load |
| progData | input | 16 | Program memory read data |
| rdData | output | 4 | Combinational read of the accessed word |
| rowSel | output | 4 | Current row register |
| progAddr | output | 10 | Program memory read address |
| busy | output | 1 | High while a port-read transfer is in progress |

## Verification
The bench builds the block with its default parameters: 4-bit nibbles, rows and columns, a 16-bit table register and a 10-bit program address. With these values the whole 256-word array can be filled and compared word by word. Table loads reach both ends of the program address range. A four-nibble transfer that starts at column 14 wraps past column 15, which checks the wrap within one row. The 4-bit row register can reach row 0 indirectly, as well as the rows 1 to 3 that direct access cannot reach.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ROW_MEM   = 3'd2,
    OP_ROW_IMM   = 3'd3,
    OP_ROW_PORT  = 3'd4,
    OP_TBL_LOAD  = 3'd5,
    OP_PORT_READ = 3'd6
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrDirect;
    logic             rowLdMem;
    logic             rowLdIn;
    logic             tblLd;
    logic             startXfer;
    logic             xferWr;
    logic [IDX_W-1:0] nibIdx;
  } strobes_t;
endpackage

// File: rtl/nbm_ctrl.sv
module nbm_ctrl #(
  parameter int NIBS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        op,
  output nbm_pkg::strobes_t stb,
  output logic              busy
);
  import nbm_pkg::*;
  localparam int CW = (NIBS > 1) ? $clog2(NIBS) : 1;

  logic [CW-1:0] cnt;
  logic          idle;
  op_e           opE;

  assign opE  = op_e'(op);
  assign idle = !busy;

  always_comb begin
    stb.wrDirect  = idle && (opE == OP_WRITE);
    stb.rowLdMem  = idle && (opE == OP_ROW_MEM);
    stb.rowLdIn   = idle && ((opE == OP_ROW_IMM) || (opE == OP_ROW_PORT));
    stb.tblLd     = idle && (opE == OP_TBL_LOAD);
    stb.startXfer = idle && (opE == OP_PORT_READ);
    stb.xferWr    = busy;
    stb.nibIdx    = IDX_W'(cnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (stb.startXfer) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == CW'(NIBS - 1)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nbm_datapath.sv
module nbm_datapath #(
  parameter int NIB_W  = 4,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int TBL_W  = 16,
  parameter int PA_W   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  nbm_pkg::strobes_t stb,
  input  logic              indirect,
  input  logic [COL_W-1:0]  col,
  input  logic [NIB_W-1:0]  wrData,
  input  logic [PA_W-1:0]   tblAddr,
  input  logic [TBL_W-1:0]  progData,
  output logic [NIB_W-1:0]  rdData,
  output logic [ROW_W-1:0]  rowSel,
  output logic [PA_W-1:0]   progAddr,
  output logic [TBL_W-1:0]  tblData
);
  localparam int AW    = ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;

  logic [NIB_W-1:0] mem [DEPTH];
  logic [ROW_W-1:0] accRow, xferRow;
  logic [COL_W-1:0] xferCol;
  logic [AW-1:0]    accAddr, wrAddr;
  logic [NIB_W-1:0] wrVal;
  logic             memWe;

  assign accRow   = indirect ? rowSel : '0;
  assign accAddr  = {accRow, col};
  assign rdData   = mem[accAddr];
  assign progAddr = tblAddr;

  always_comb begin
    memWe = stb.xferWr || stb.wrDirect;
    if (stb.xferWr) begin
      wrAddr = {xferRow, xferCol + COL_W'(stb.nibIdx)};
      wrVal  = NIB_W'(tblData >> (NIB_W * int'(stb.nibIdx)));
    end else begin
      wrAddr = accAddr;
      wrVal  = wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (memWe) mem[wrAddr] <= wrVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowSel  <= '0;
      tblData <= '0;
      xferRow <= '0;
      xferCol <= '0;
    end else begin
      if (stb.rowLdMem)     rowSel <= ROW_W'(rdData);
      else if (stb.rowLdIn) rowSel <= ROW_W'(wrData);
      if (stb.tblLd) tblData <= progData;
      if (stb.startXfer) begin
        xferRow <= accRow;
        xferCol <= col;
      end
    end
  end
endmodule

// File: rtl/nibble_bank_mem.sv
module nibble_bank_mem #(
  parameter int NIB_W = 4,
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int TBL_W = 16,
  parameter int PA_W  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       op,
  input  logic             indirect,
  input  logic [COL_W-1:0] col,
  input  logic [NIB_W-1:0] wrData,
  input  logic [PA_W-1:0]  tblAddr,
  input  logic [TBL_W-1:0] progData,
  output logic [NIB_W-1:0] rdData,
  output logic [ROW_W-1:0] rowSel,
  output logic [PA_W-1:0]  progAddr,
  output logic             busy
);
  localparam int NIBS = TBL_W / NIB_W;

  nbm_pkg::strobes_t stb;
  logic [TBL_W-1:0]  tblView;

  nbm_ctrl #(.NIBS(NIBS)) u_ctrl (
    .clk(clk), .rstN(rstN), .op(op), .stb(stb), .busy(busy)
  );

  nbm_datapath #(
    .NIB_W(NIB_W), .ROW_W(ROW_W), .COL_W(COL_W), .TBL_W(TBL_W), .PA_W(PA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .indirect(indirect), .col(col),
    .wrData(wrData), .tblAddr(tblAddr), .progData(progData),
    .rdData(rdData), .rowSel(rowSel), .progAddr(progAddr), .tblData(tblView)
  );
endmodule

// File: rtl/nbm_checker.sv
module nbm_checker #(
  parameter int NIBS  = 4,
  parameter int ROW_W = 4,
  parameter int TBL_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       op,
  input logic             busy,
  input logic [ROW_W-1:0] rowSel,
  input logic [TBL_W-1:0] tblView,
  input logic [TBL_W-1:0] progData
);
  logic [7:0] busyRun;
  logic       rowOp;

  assign rowOp = (op == 3'd2) || (op == 3'd3) || (op == 3'd4);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else       busyRun <= busy ? busyRun + 8'd1 : 8'd0;
  end

  a_r5_row_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(!busy && rowOp) |=> rowSel == $past(rowSel));

  a_r6_table_load: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && op == 3'd5) |=> tblView == $past(progData));

  a_r6_table_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(!busy && op == 3'd5) |=> $stable(tblView));

  a_r7_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && op == 3'd6) |=> busy);

  a_r7_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyRun < 8'(NIBS));

  a_r7_full_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == 8'(NIBS));

  a_r8_row_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> rowSel == $past(rowSel));

  always @(posedge clk) begin
    if (!rstN) begin
      a_r10_reset_clear: assert (rowSel == '0 && tblView == '0 && !busy);
    end
  end
endmodule

bind nibble_bank_mem nbm_checker #(.NIBS(NIBS), .ROW_W(ROW_W), .TBL_W(TBL_W)) u_chk (
  .clk(clk), .rstN(rstN), .op(op), .busy(busy), .rowSel(rowSel),
  .tblView(tblView), .progData(progData)
);

// File: tb/tb_nibble_bank_mem.sv
`timescale 1ns/1ps
module tb_nibble_bank_mem;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  op;
  logic        indirect;
  logic [3:0]  col, wrData;
  logic [9:0]  tblAddr;
  logic [15:0] progData;
  logic [3:0]  rdData, rowSel;
  logic [9:0]  progAddr;
  logic        busy;

  int nChk = 0, nErr = 0;
  logic [3:0]  refMem [256];
  logic [3:0]  refRow;
  logic [15:0] refTbl;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] progWord(input logic [9:0] a);
    return 16'((32'(a) * 32'h9E37) ^ 32'hC3A5);
  endfunction

  assign progData = progWord(progAddr);

  nibble_bank_mem dut (
    .clk(clk), .rstN(rstN), .op(op), .indirect(indirect), .col(col),
    .wrData(wrData), .tblAddr(tblAddr), .progData(progData),
    .rdData(rdData), .rowSel(rowSel), .progAddr(progAddr), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addrOf(input logic ind, input logic [3:0] c);
    return {ind ? refRow : 4'h0, c};
  endfunction

  // model of a non-transfer operation accepted while idle
  task automatic modelOp(input int o, input logic ind, input logic [3:0] c,
                         input logic [3:0] d, input logic [9:0] ta);
    logic [7:0] a = addrOf(ind, c);
    case (o)
      1: refMem[a] = d;
      2: refRow = refMem[a];
      3, 4: refRow = d;
      5: refTbl = progWord(ta);
      default: ;
    endcase
  endtask

  // inputs are driven at the falling edge; returns at the next falling edge
  task automatic doOp(input int o, input logic ind, input logic [3:0] c,
                      input logic [3:0] d, input logic [9:0] ta);
    op = 3'(o); indirect = ind; col = c; wrData = d; tblAddr = ta;
    @(posedge clk);
    @(negedge clk);
    op = 3'd0;
    modelOp(o, ind, c, d, ta);
  endtask

  task automatic readChk(input string req, input logic ind, input logic [3:0] c);
    indirect = ind; col = c;
    #1;
    chk(req, int'(rdData), int'(refMem[addrOf(ind, c)]));
  endtask

  task automatic portRead(input logic ind, input logic [3:0] c, input bit inject);
    logic [7:0] base = addrOf(ind, c);
    logic [3:0] rowB = ind ? refRow : 4'h0;
    logic [3:0] oldRow = refRow;
    op = 3'd6; indirect = ind; col = c;
    @(posedge clk);
    @(negedge clk);
    op = 3'd0;
    #1;
    chk("R7 busy k0", int'(busy), 1);
    if (inject) begin
      chk("R9 old data before write", int'(rdData), int'(refMem[base]));
      op = 3'd1; indirect = 1'b0; col = 4'd1; wrData = ~refMem[8'h01];
    end
    for (int k = 1; k < 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (inject && k == 1) begin
        op = 3'd3; wrData = ~oldRow; indirect = ind; col = c;
        #1;
        chk("R9 nibble0 after edge", int'(rdData), int'(refTbl[3:0]));
      end else if (inject && k == 2) begin
        op = 3'd5; tblAddr = 10'h155;
      end else begin
        op = 3'd0;
      end
      #1;
      chk($sformatf("R7 busy k%0d", k), int'(busy), 1);
    end
    @(posedge clk);
    @(negedge clk);
    op = 3'd0;
    #1;
    chk("R7 busy low after 4", int'(busy), 0);
    for (int k = 0; k < 4; k++)
      refMem[{rowB, 4'(c + 4'(k))}] = refTbl[4*k +: 4];
    chk("R8 row unchanged by busy ops", int'(rowSel), int'(oldRow));
    readChk("R8 ignored write", 1'b0, 4'd1);
    for (int k = 0; k < 4; k++) begin
      indirect = ind;
      col = 4'(c + 4'(k));
      #1;
      chk($sformatf("R7 nibble %0d", k), int'(rdData), int'(refTbl[4*k +: 4]));
    end
  endtask

  initial begin
    #200000;
    nErr++; nChk++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; op = 3'd0; indirect = 1'b0; col = '0; wrData = '0; tblAddr = '0;
    refRow = '0; refTbl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset rowSel", int'(rowSel), 0);
    chk("R10 reset busy", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);

    // fill every word through indirect rows
    for (int r = 0; r < 16; r++) begin
      doOp(3, 1'b0, 4'd0, 4'(r), 10'd0);
      for (int c = 0; c < 16; c++)
        doOp(1, 1'b1, 4'(c), 4'((r * 7 + c * 3) & 15), 10'd0);
    end
    for (int a = 0; a < 256; a += 37) readChk("R2 fill readback", 1'b1, 4'(a));

    // R1 direct access hits row 0 even with row 4 selected
    doOp(3, 1'b0, 4'd0, 4'd4, 10'd0);
    doOp(1, 1'b0, 4'd5, 4'hA, 10'd0);
    readChk("R1 direct read", 1'b0, 4'd5);
    readChk("R1 row4 untouched", 1'b1, 4'd5);
    // R2 rows 0 and 2 indirectly
    doOp(4, 1'b0, 4'd0, 4'd0, 10'd0);
    chk("R4 port write row", int'(rowSel), 0);
    readChk("R2 indirect row0", 1'b1, 4'd5);
    doOp(3, 1'b0, 4'd0, 4'd2, 10'd0);
    chk("R4 immediate row", int'(rowSel), 2);
    readChk("R2 indirect row2", 1'b1, 4'd9);
    // R3 row from the addressed word
    doOp(2, 1'b1, 4'd9, 4'd0, 10'd0);
    chk("R3 row from memory", int'(rowSel), int'(refRow));
    // R5 other codes keep the row
    doOp(7, 1'b0, 4'd0, 4'hF, 10'd0);
    chk("R5 code 7 keeps row", int'(rowSel), int'(refRow));
    doOp(1, 1'b1, 4'd3, 4'h6, 10'd0);
    chk("R5 write keeps row", int'(rowSel), int'(refRow));

    // R6 table load at both ends of the program range, then R7 with wrap
    tblAddr = 10'h3FF; #1;
    chk("R6 progAddr follows", int'(progAddr), 32'h3FF);
    doOp(5, 1'b0, 4'd0, 4'd0, 10'h3FF);
    doOp(3, 1'b0, 4'd0, 4'd3, 10'd0);
    portRead(1'b1, 4'd14, 1'b1);
    doOp(5, 1'b0, 4'd0, 4'd0, 10'h000);
    portRead(1'b0, 4'd0, 1'b0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int o = int'($urandom % 8);
      logic ind = 1'($urandom);
      logic [3:0] c = 4'($urandom);
      if (o == 6) portRead(ind, c, 1'($urandom));
      else doOp(o, ind, c, 4'($urandom), 10'($urandom));
      chk("R5 row model", int'(rowSel), int'(refRow));
      readChk("R2 random read", 1'($urandom), 4'($urandom));
    end

    // R10 reset keeps memory, clears row and table
    rstN = 1'b0;
    @(negedge clk);
    chk("R10 row cleared", int'(rowSel), 0);
    rstN = 1'b1;
    refRow = '0; refTbl = '0;
    @(negedge clk);
    for (int c = 0; c < 16; c += 5) readChk("R10 memory kept", 1'b0, 4'(c));
    portRead(1'b0, 4'd8, 1'b0);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule